// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block is a per-channel countdown timer that watches a receive FIFO and raises timeout service requests. One timer serves two kinds of timeout. A stale-data timeout fires when characters are waiting in the FIFO but their number stays below the service threshold until the timer runs out. A no-new-data timeout fires when software has emptied the FIFO and no further character arrives before the timer runs out.

The timer reloads from a programmable period whenever a character is written into the FIFO, and also when the last character is read out. It counts down one step per prescaler tick, which comes from outside as a single-cycle strobe. The FIFO state at the moment of expiry decides which request, if any, is raised. Each request stays high until its own acknowledge arrives.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset both request outputs are low and the timer is idle, so ticks cause no request until a reload happens.
- R2: A FIFO write strobe reloads the timer from `period_i`. With a period P of 1 or more, expiry happens on the P-th tick after the reload and on no earlier tick.
- R3: A last-character-removed strobe also reloads the timer from `period_i`, with the same expiry timing as R2.
- R4: The timer moves only on cycles where `tick_i` is high. Any number of clock cycles without a tick leaves the timer where it is.
- R5: If, on the expiry cycle, `fifo_level_i` is non-zero and below `thresh_i`, `stale_req_o` goes high after that clock edge. This timeout has no enable of its own.
- R6: If, on the expiry cycle, the level is at or above the threshold, or the level is zero and no removal event is pending, no request is raised.
- R7: If the last-character-removed strobe came after the most recent FIFO write, and the level is zero on the expiry cycle, `nnd_req_o` goes high after that clock edge.
- R8: A FIFO write cancels any pending no-new-data arming. When a write and a removal come in the same cycle, the write wins and the timer reloads.
- R9: With `rx_irq_en_i` low on the expiry cycle, no request is raised. That expiry is used up, and later ticks raise nothing.
- R10: After expiry the timer stays at zero and does not wrap. Further ticks raise no new request until the next reload.
- R11: Each request stays high until its own acknowledge (`ack_stale_i` or `ack_nnd_i`). Acknowledging one request leaves the other unchanged.
- R12: A period of zero makes the timer expire on the first tick after the reload.
- R13: A reload in the same cycle as a tick wins. That tick is not counted, and the full period starts again.
- R14: If an expiry sets a request in the same cycle as that request's acknowledge, the request is high after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | PERIOD_W | Reload value of the timer, in ticks |
| tick_i | input | 1 | Prescaler tick strobe, one cycle wide |
| char_wr_i | input | 1 | A character was written into the FIFO this cycle |
| last_rd_i | input | 1 | The last character was read out of the FIFO this cycle |
| fifo_level_i | input | LEVEL_W | Current number of characters in the FIFO |
| thresh_i | input | LEVEL_W | Service threshold in characters |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| ack_stale_i | input | 1 | Clears the stale-data request |
| ack_nnd_i | input | 1 | Clears the no-new-data request |
| stale_req_o | output | 1 | Stale-data timeout request |
| nnd_req_o | output | 1 | No-new-data timeout request |

## Verification
Three pairs of events can fall in the same cycle: a reload with a tick, a write with a removal, and an expiry with the acknowledge of the request it sets. The bench drives each pair on one clock edge through the vector table. For reload with tick, it counts the ticks to the next request to show that the colliding tick was not counted. For write with removal, it checks that no no-new-data request appears when the level is zero at expiry. For expiry with acknowledge, it checks that the request is still high on the next sample.

// File: rtl/rit_pkg.sv
package rit_pkg;

  typedef enum logic [1:0] {
    EXP_NONE  = 2'd0,
    EXP_STALE = 2'd1,
    EXP_NND   = 2'd2
  } exp_kind_e;

  // Decide the timeout kind from the FIFO state seen on the expiry cycle.
  function automatic exp_kind_e classify(input logic armed,
                                         input logic empty,
                                         input logic below);
    if (empty && armed)       return EXP_NND;
    else if (!empty && below) return EXP_STALE;
    else                      return EXP_NONE;
  endfunction

endpackage

// File: rtl/rit_countdown.sv
module rit_countdown #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reload,
  input  logic [PERIOD_W-1:0] period,
  input  logic                tick,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                live_q,
  output logic                expire
);

  // The step that consumes the final count (or a zero period) ends the run.
  function automatic logic final_step(input logic [PERIOD_W-1:0] c);
    return c <= PERIOD_W'(1);
  endfunction

  assign expire = tick && live_q && !reload && final_step(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (reload) begin
      cnt_q  <= period;
      live_q <= 1'b1;
    end else if (tick && live_q) begin
      if (final_step(cnt_q)) begin
        cnt_q  <= '0;
        live_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - PERIOD_W'(1);
      end
    end
  end

endmodule

// File: rtl/rit_arm.sv
module rit_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic emptied,
  input  logic wrote,
  output logic armed_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (wrote)   armed_q <= 1'b0;
    else if (emptied) armed_q <= 1'b1;
  end

endmodule

// File: rtl/rit_req_latch.sv
module rit_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   req_q <= 1'b0;
    else if (set) req_q <= 1'b1;
    else if (ack) req_q <= 1'b0;
  end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
  import rit_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int LEVEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                tick_i,
  input  logic                char_wr_i,
  input  logic                last_rd_i,
  input  logic [LEVEL_W-1:0]  fifo_level_i,
  input  logic [LEVEL_W-1:0]  thresh_i,
  input  logic                rx_irq_en_i,
  input  logic                ack_stale_i,
  input  logic                ack_nnd_i,
  output logic                stale_req_o,
  output logic                nnd_req_o
);

  localparam int NREQ = 2;

  logic                reload_w;
  logic                expire_w;
  logic [PERIOD_W-1:0] cnt_q;
  logic                live_q;
  logic                nnd_arm_q;
  logic                empty_w;
  logic                below_w;
  exp_kind_e           kind_w;
  logic [NREQ-1:0]     set_w;
  logic [NREQ-1:0]     ack_w;
  logic [NREQ-1:0]     req_w;

  assign reload_w = char_wr_i || last_rd_i;
  assign empty_w  = (fifo_level_i == '0);
  assign below_w  = (fifo_level_i < thresh_i);

  rit_countdown #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload_w),
    .period (period_i),
    .tick   (tick_i),
    .cnt_q  (cnt_q),
    .live_q (live_q),
    .expire (expire_w)
  );

  rit_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .emptied (last_rd_i),
    .wrote   (char_wr_i),
    .armed_q (nnd_arm_q)
  );

  assign kind_w = classify(nnd_arm_q, empty_w, below_w);

  assign set_w[0] = expire_w && rx_irq_en_i && (kind_w == EXP_STALE);
  assign set_w[1] = expire_w && rx_irq_en_i && (kind_w == EXP_NND);
  assign ack_w    = {ack_nnd_i, ack_stale_i};

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    rit_req_latch u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_w[g]),
      .ack   (ack_w[g]),
      .req_q (req_w[g])
    );
  end

  assign stale_req_o = req_w[0];
  assign nnd_req_o   = req_w[1];

endmodule

// File: rtl/rx_idle_timer_chk.sv
module rx_idle_timer_chk #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PERIOD_W-1:0] period_i,
  input logic                tick_i,
  input logic                char_wr_i,
  input logic                rx_irq_en_i,
  input logic                ack_stale_i,
  input logic                ack_nnd_i,
  input logic                stale_req_o,
  input logic                nnd_req_o,
  input logic                reload_w,
  input logic                expire_w,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic                live_q,
  input logic                nnd_arm_q
);

  // R2
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_w |=> (cnt_q == $past(period_i)) && live_q);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !reload_w) |=> $stable(cnt_q) && $stable(live_q));

  // R10
  stopped_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_q && !reload_w) |=> !live_q && (cnt_q == '0));

  // R8
  write_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_wr_i |=> !nnd_arm_q);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !rx_irq_en_i && !stale_req_o && !nnd_req_o) |=> !stale_req_o && !nnd_req_o);

  // R11
  stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_req_o && !ack_stale_i) |=> stale_req_o);

  // R11
  nnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nnd_req_o && !ack_nnd_i) |=> nnd_req_o);

  // R5
  stale_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_req_o) |-> $past(expire_w));

  // R7
  nnd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nnd_req_o) |-> $past(expire_w) && $past(nnd_arm_q));

endmodule

bind rx_idle_timer rx_idle_timer_chk #(.PERIOD_W(PERIOD_W)) chk_i (.*);

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb_top;

  localparam int PW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period_i = '0;
  logic          tick_i = 1'b0, char_wr_i = 1'b0, last_rd_i = 1'b0;
  logic [LW-1:0] fifo_level_i = '0, thresh_i = '0;
  logic          rx_irq_en_i = 1'b0, ack_stale_i = 1'b0, ack_nnd_i = 1'b0;
  logic          stale_req_o, nnd_req_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rx_idle_timer #(.PERIOD_W(PW), .LEVEL_W(LW)) dut_i (.*);

  typedef struct packed {
    logic          wr, rd, tk, as, an, en;
    logic [LW-1:0] lvl, th;
    logic [PW-1:0] per;
    logic          es, ens;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    // wr rd tk as an en lvl th per es en
    '{1,0,0,0,0,1, 1,4, 3, 0,0},  // 0  R2 write reload
    '{0,0,1,0,0,1, 1,4, 3, 0,0},  // 1
    '{0,0,0,0,0,1, 1,4, 3, 0,0},  // 2  R4 no tick
    '{0,0,1,0,0,1, 1,4, 3, 0,0},  // 3
    '{0,0,1,0,0,1, 1,4, 3, 1,0},  // 4  R5 stale
    '{0,0,1,0,0,1, 1,4, 3, 1,0},  // 5  R10 held, no wrap
    '{0,0,0,1,0,1, 1,4, 3, 0,0},  // 6  R11 ack
    '{0,0,1,0,0,1, 1,4, 3, 0,0},  // 7  R10 stopped
    '{0,1,0,0,0,1, 0,4, 3, 0,0},  // 8  R3 removal reload
    '{0,0,1,0,0,1, 0,4, 3, 0,0},  // 9
    '{0,0,1,0,0,1, 0,4, 3, 0,0},  // 10
    '{0,0,1,0,0,1, 0,4, 3, 0,1},  // 11 R7 no-new-data
    '{0,0,0,0,1,1, 0,4, 3, 0,0},  // 12
    '{1,0,0,0,0,1, 1,1, 3, 0,0},  // 13 R6 level at threshold
    '{0,0,1,0,0,1, 1,1, 3, 0,0},  // 14
    '{0,0,1,0,0,1, 1,1, 3, 0,0},  // 15
    '{0,0,1,0,0,1, 1,1, 3, 0,0},  // 16
    '{1,1,0,0,0,1, 0,4, 3, 0,0},  // 17 R8 write beats removal
    '{0,0,1,0,0,1, 0,4, 3, 0,0},  // 18
    '{0,0,1,0,0,1, 0,4, 3, 0,0},  // 19
    '{0,0,1,0,0,1, 0,4, 3, 0,0},  // 20
    '{1,0,0,0,0,0, 2,4, 3, 0,0},  // 21 R9 disabled
    '{0,0,1,0,0,0, 2,4, 3, 0,0},  // 22
    '{0,0,1,0,0,0, 2,4, 3, 0,0},  // 23
    '{0,0,1,0,0,0, 2,4, 3, 0,0},  // 24
    '{0,0,1,0,0,1, 2,4, 3, 0,0},  // 25 R9 expiry used up
    '{1,0,0,0,0,1, 2,4, 3, 0,0},  // 26
    '{1,0,1,0,0,1, 2,4, 3, 0,0},  // 27 R13 reload with tick
    '{0,0,1,0,0,1, 2,4, 3, 0,0},  // 28
    '{0,0,1,0,0,1, 2,4, 3, 0,0},  // 29
    '{0,0,1,0,0,1, 2,4, 3, 1,0},  // 30
    '{0,0,0,1,0,1, 2,4, 3, 0,0},  // 31
    '{1,0,0,0,0,1, 1,4, 0, 0,0},  // 32 R12 zero period
    '{0,0,1,0,0,1, 1,4, 0, 1,0},  // 33
    '{0,1,0,0,0,1, 0,4, 0, 1,0},  // 34
    '{0,0,1,1,0,1, 0,4, 0, 0,1},  // 35
    '{0,0,0,1,0,1, 0,4, 0, 0,1},  // 36 R11 other ack
    '{1,0,0,0,0,1, 1,4, 1, 0,1},  // 37
    '{0,0,1,1,0,1, 1,4, 1, 1,1},  // 38 R14 set beats ack
    '{0,0,0,1,1,1, 1,4, 1, 0,0}   // 39
  };

  task automatic drive(input vec_t v);
    @(negedge clk);
    char_wr_i = v.wr; last_rd_i = v.rd; tick_i = v.tk;
    ack_stale_i = v.as; ack_nnd_i = v.an; rx_irq_en_i = v.en;
    fifo_level_i = v.lvl; thresh_i = v.th; period_i = v.per;
    @(posedge clk);
    #5;
    char_wr_i = 0; last_rd_i = 0; tick_i = 0; ack_stale_i = 0; ack_nnd_i = 0;
  endtask

  task automatic check(input string req, input logic es, input logic en);
    n_vec++;
    if (stale_req_o !== es || nnd_req_o !== en) begin
      n_bad++;
      $display("FAIL %s: stale/nnd got %b%b expected %b%b", req, stale_req_o, nnd_req_o, es, en);
    end
  endtask

  vec_t idle_v, tick_v;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0);
    rst_n = 1'b1;
    idle_v = '{0,0,0,0,0,1, 1,4, 3, 0,0};
    tick_v = idle_v; tick_v.tk = 1;
    for (int i = 0; i < 4; i++) drive(tick_v);
    @(negedge clk);
    check("R1 idle after reset", 0, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R-table vector %0d", i), VECS[i].es, VECS[i].ens);
    end

    // R4: long gap without ticks does not advance the timer
    idle_v.wr = 1; drive(idle_v); idle_v.wr = 0;
    for (int i = 0; i < 50; i++) drive(idle_v);
    @(negedge clk);
    check("R4 no ticks", 0, 0);
    drive(tick_v); drive(tick_v);
    @(negedge clk);
    check("R4 two ticks", 0, 0);
    drive(tick_v);
    @(negedge clk);
    check("R4 third tick", 1, 0);

    // R1: reset mid-run clears a held request
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) drive(tick_v);
    @(negedge clk);
    check("R1 idle after second reset", 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule